// File: doc/BRIEF.md
# Unaligned Partial Store Lane Generator

This block turns a store-left or store-right partial store of a 32-bit or 64-bit register into one aligned write on a 64-bit memory bus. A request carries the byte address, the register value, an endianness bit, the direction of the partial store (left or right) and the operand size. From these the block works out which bytes of the addressed word get written, and which register byte lands in each bus lane. It then presents the result as a single write: an aligned address, a byte-enable mask and lane-aligned data.

The lane offset is the low address bits inside the operand word. For little-endian it is inverted. Store-left begins at the addressed byte with the most significant register byte and walks toward the word edge. Store-right begins there with the least significant byte and walks the other way. Big-endian walks toward higher addresses and little-endian toward lower ones. The request and the write each use a valid/ready handshake. One output register sits between them.

Top module: `partial_store_lanes`

## Requirements
- R1: The write address equals the request address with its three low bits cleared.
- R2: Bus lane i (data bits 8i+7..8i, mask bit i) holds the byte at address write-address + i.
- R3: The lane offset is the address modulo N, where N is 4 for a word and 8 for a doubleword. For little-endian the offset is XORed with N-1. The step is +1 byte for big-endian and -1 byte for little-endian.
- R4: Store-left writes register byte N-1 at the request address and register byte N-1-k at address + k·step. Byte k is written only when the offset is at most N-1-k.
- R5: Store-right writes register byte 0 at the request address and register byte k at address − k·step. Byte k is written only when the offset is at least k.
- R6: A word operation enables only lanes inside the 4-byte half selected by address bit 2. It uses only the low 32 bits of the register.
- R7: A store-left with offset 0, or a store-right with offset N-1, enables all N lanes of the operand word.
- R8: Lanes whose mask bit is clear carry zero data.
- R9: req_ready is high exactly when no write is pending or wr_ready is high. An accepted request appears on the write port in the next cycle. It stays unchanged until wr_ready is seen.
- R10: After reset wr_valid is low.
- R11: Every issued mask is non-zero and is one contiguous run of lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address of the partial store |
| req_data | input | 64 | Register value |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| req_left | input | 1 | 1 = store-left, 0 = store-right |
| req_dword | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| wr_valid | output | 1 | Write pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | 8-byte-aligned write address |
| wr_mask | output | 8 | Byte enables, bit i = lane i |
| wr_data | output | 64 | Lane-aligned write data |

## Verification
The in-design assertions assume every request field is a known value whenever req_valid is high. They also assume that wr_ready may change freely from cycle to cycle, without any rule tied to wr_valid. The stimulus drives every request field each cycle, including idle cycles. It first walks every combination of offset, endianness, direction and size with the sink always ready. It then mixes random requests with random back-pressure, so that stalls hit both fresh and pending writes.

// File: rtl/partial_store_lanes.sv
module partial_store_lanes #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic              req_big,
  input  logic              req_left,
  input  logic              req_dword,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_mask,
  output logic [63:0]       wr_data
);

  logic [2:0]  off, top;
  logic        up;
  logic [7:0]  n_mask;
  logic [63:0] n_data;
  logic        q_dw;

  assign off       = req_dword ? req_addr[2:0] : {1'b0, req_addr[1:0]};
  assign top       = req_dword ? 3'd7 : 3'd3;
  assign up        = (req_left == req_big);
  assign req_ready = !wr_valid || wr_ready;

  always_comb begin
    logic [2:0] li, p, idx;
    logic       in_w, hit;
    n_mask = '0;
    n_data = '0;
    for (int i = 0; i < 8; i++) begin
      li   = 3'(i);
      p    = req_dword ? li : {1'b0, li[1:0]};
      in_w = req_dword || (li[2] == req_addr[2]);
      hit  = in_w && (up ? (p >= off) : (p <= off));
      if (req_left) idx = req_big ? (top - p + off) : (top - off + p);
      else          idx = req_big ? (off - p) : (p - off);
      n_mask[i] = hit;
      n_data[8*i +: 8] = hit ? req_data[{idx, 3'b000} +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_mask  <= '0;
      wr_data  <= '0;
      q_dw     <= 1'b0;
    end else if (req_valid && req_ready) begin
      wr_valid <= 1'b1;
      wr_addr  <= {req_addr[ADDR_W-1:3], 3'b000};
      wr_mask  <= n_mask;
      wr_data  <= n_data;
      q_dw     <= req_dword;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_mask) && $stable(wr_data) && $stable(wr_addr));

  // R9
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> wr_valid);

  // R11
  mask_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $countones({1'b0, wr_mask} ^ {wr_mask, 1'b0}) == 2);

  // R6
  word_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !q_dw |-> (wr_mask[7:4] == 4'h0 || wr_mask[3:0] == 4'h0));

  // R8
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & {{8{!wr_mask[7]}}, {8{!wr_mask[6]}}, {8{!wr_mask[5]}}, {8{!wr_mask[4]}},
                              {8{!wr_mask[3]}}, {8{!wr_mask[2]}}, {8{!wr_mask[1]}}, {8{!wr_mask[0]}}}) == 64'h0));

endmodule

// File: tb/partial_store_lanes_bench.sv
module partial_store_lanes_bench;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_big = 0, req_left = 0, req_dword = 0, wr_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic req_ready, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_mask;
  logic [63:0] wr_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  partial_store_lanes #(.ADDR_W(AW)) u_partial_store_lanes (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_big(req_big), .req_left(req_left),
    .req_dword(req_dword), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data));

  // model state
  bit          m_valid = 0, x_valid;
  logic [AW-1:0] m_addr, x_addr;
  logic [7:0]  m_mask, x_mask;
  logic [63:0] m_data, x_data;
  bit          m_dw, x_dw, m_left, x_left;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: walk bytes from the addressed byte with the stated step (R2, R3, R4, R5)
  task automatic ref_store(input logic [AW-1:0] a, input logic [63:0] d, input bit be,
                           input bit left, input bit dw,
                           output logic [7:0] mk, output logic [63:0] dt);
    int n, o, lm, dir, pos, rb;
    n = dw ? 8 : 4;
    o = int'(a[2:0]) & (n - 1);
    lm = be ? o : (o ^ (n - 1));
    dir = be ? 1 : -1;
    mk = '0; dt = '0;
    for (int k = 0; k < n; k++) begin
      if (left ? (lm <= n - 1 - k) : (lm >= k)) begin
        rb  = left ? (n - 1 - k) : k;
        pos = int'(a[2:0]) + (left ? k * dir : -k * dir);
        mk[pos] = 1'b1;
        dt[8*pos +: 8] = d[8*rb +: 8];
      end
    end
  endtask

  task automatic cycle(input bit v, input logic [AW-1:0] a, input logic [63:0] d,
                       input bit be, input bit left, input bit dw, input bit rdy);
    logic [7:0] mk; logic [63:0] dt; bit exp_rdy;
    @(negedge clk);
    m_valid = x_valid; m_addr = x_addr; m_mask = x_mask; m_data = x_data; m_dw = x_dw; m_left = x_left;
    chk(wr_valid == m_valid, "R9 wr_valid", 64'(wr_valid), 64'(m_valid));
    if (m_valid && wr_valid) begin
      chk(wr_addr == m_addr, "R1 wr_addr", 64'(wr_addr), 64'(m_addr));
      chk(wr_mask == m_mask, m_left ? "R3 R4 wr_mask" : "R3 R5 wr_mask", 64'(wr_mask), 64'(m_mask));
      chk(wr_data == m_data, "R2 R4 R5 wr_data", wr_data, m_data);
      if (!m_dw) chk(wr_mask[7:4] == 0 || wr_mask[3:0] == 0, "R6 half", 64'(wr_mask), 64'(m_mask));
      chk($countones({1'b0, wr_mask} ^ {wr_mask, 1'b0}) == 2, "R11 run", 64'(wr_mask), 64'(m_mask));
      for (int i = 0; i < 8; i++)
        if (!wr_mask[i]) chk(wr_data[8*i +: 8] == 8'h0, "R8 idle lane", wr_data, m_data);
    end
    req_valid = v; req_addr = a; req_data = d; req_big = be; req_left = left; req_dword = dw; wr_ready = rdy;
    #0.5;
    exp_rdy = !m_valid || rdy;
    chk(req_ready == exp_rdy, "R9 req_ready", 64'(req_ready), 64'(exp_rdy));
    x_valid = m_valid; x_addr = m_addr; x_mask = m_mask; x_data = m_data; x_dw = m_dw; x_left = m_left;
    if (v && exp_rdy) begin
      ref_store(a, d, be, left, dw, mk, dt);
      x_valid = 1; x_addr = {a[AW-1:3], 3'b000}; x_mask = mk; x_data = dt; x_dw = dw; x_left = left;
    end else if (rdy) x_valid = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    x_valid = 0; x_addr = '0; x_mask = '0; x_data = '0; x_dw = 0; x_left = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk(wr_valid == 1'b0, "R10 reset", 64'(wr_valid), 64'd0);
    rst_n = 1;
    // every offset, endianness, direction, size
    for (int dw = 0; dw < 2; dw++)
      for (int be = 0; be < 2; be++)
        for (int lf = 0; lf < 2; lf++)
          for (int o = 0; o < 8; o++) begin
            logic [AW-1:0] a;
            logic [7:0] mk; logic [63:0] dt;
            a = AW'(32'h1000_0040 + o);
            ref_store(a, 64'hF1E2_D3C4_B5A6_9788, be[0], lf[0], dw[0], mk, dt);
            cycle(1, a, 64'hF1E2_D3C4_B5A6_9788, be[0], lf[0], dw[0], 1);
            // R7: offset 0 left / max offset right enables the whole operand word
            if ((lf == 1 && ((be == 1) ? (o % (dw ? 8 : 4)) == 0 : (o % (dw ? 8 : 4)) == (dw ? 7 : 3))) ||
                (lf == 0 && ((be == 1) ? (o % (dw ? 8 : 4)) == (dw ? 7 : 3) : (o % (dw ? 8 : 4)) == 0)))
              chk($countones(mk) == (dw ? 8 : 4), "R7 full word", 64'(mk), 64'(dw ? 8 : 4));
          end
    // R6: upper register half ignored for words
    cycle(1, 32'h2000_0004, 64'hDEAD_BEEF_0000_0000, 1, 1, 0, 1);
    cycle(0, '0, '0, 0, 0, 0, 1);
    // random traffic with back-pressure
    for (int n = 0; n < 3000; n++)
      cycle(1'($urandom_range(0, 3) != 0), AW'($urandom), {$urandom, $urandom},
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 2) != 0));
    for (int n = 0; n < 4; n++) cycle(0, '0, '0, 0, 0, 0, 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule